// File: doc/BRIEF.md
# Chip Select Access Terminator

This block times the bus cycle for a single memory region selected by a chip select. A request that hits the region raises the chip select one cycle later. The block then ends the cycle in one of two ways. It can count a programmed number of system-clock wait states and then issue its own transfer acknowledge. It can also leave termination to an external acknowledge input, and a built-in timeout reports a bus error if that acknowledge never arrives.

An 8-bit option register sets the behaviour of the region. It holds the wait count, a direction protection that can make the region read-only or write-only, and a read hold flag. The hold flag keeps the address and attribute qualifier valid for one extra cycle after a read. Decoding the region's base address is done outside the block, so the block only sees a hit signal. The block takes a snapshot of the option register when it accepts an access. Changes written to the register therefore apply from the next access.

Top module: `cs_access_term`

## Requirements
- R1: When the block is idle and `req_valid` and `req_hit` are both high at a clock edge, `cs_active` goes high in the next cycle. Requests that arrive while an access is active or in its hold cycle are dropped. A request with `req_hit` low starts nothing.
- R2: The option register is loaded from `cfg_wdata` when `cfg_we` is high. Bits [4:0] hold the wait count. For a count N from 0 to 30, `cs_active` stays high for N+1 cycles and `ack_out` is high in the last of those cycles, so a count of 10 gives a 10-clock wait.
- R3: `ack_out` lasts exactly one cycle, and `cs_active` is low in the cycle after it.
- R4: A wait count of 31 turns off the internal acknowledge. The access then ends in the cycle in which `ext_ack` is high, and `ack_out` is high in that same cycle. `ext_ack` has no effect while no access is active.
- R5: With a wait count of 31 and no `ext_ack`, `bus_err` pulses in the 256th cycle of `cs_active`. In that case `ack_out` does not assert, and the block returns to idle.
- R6: Bit 7 is the read hold flag. When it is set, `addr_valid` stays high for one cycle after `cs_active` falls at the end of a read. Writes, and reads with the flag cleared, drop `addr_valid` together with `cs_active`. `addr_valid` is high whenever `cs_active` is high.
- R7: Bit 5 turns protection on, and bit 6 selects write-only (1) or read-only (0). An access whose direction conflicts with the protection raises `prot_err` for one cycle, in the cycle after it is accepted. Such an access asserts no `cs_active`, `ack_out` or `addr_valid`.
- R8: After reset the wait count equals the parameter `WS_RESET` (default 30). Protection and the read hold flag are off after reset, and all outputs are low.
- R9: An option write made during an active access has no effect on that access. It applies from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Write strobe for the option register |
| cfg_wdata | input | 8 | Option value: [4:0] wait count, [5] protect enable, [6] write-only, [7] read hold |
| req_valid | input | 1 | A bus access is presented |
| req_write | input | 1 | Direction of the access: 1 = write, 0 = read |
| req_hit | input | 1 | The access address falls in this region |
| ext_ack | input | 1 | External transfer acknowledge, used when the wait count is 31 |
| cs_active | output | 1 | Chip select, active high |
| ack_out | output | 1 | One-cycle transfer acknowledge |
| addr_valid | output | 1 | Address and attribute qualifier, including the optional read hold cycle |
| prot_err | output | 1 | One-cycle pulse on a protection violation |
| bus_err | output | 1 | One-cycle pulse when the external acknowledge times out |

## Verification
The assertions check on every cycle the rules that depend only on the shapes of the outputs. These are: the chip select rises only after an accepted request, the acknowledge is a single pulse that ends the chip select, a violation stays silent on the bus, the hold cycle lasts at most one cycle, and the chip select never runs longer than the timeout window. Some behaviours can only be shown by the bench's scenarios, because they depend on the programmed register value or on when an input arrives. These are: the exact number of wait cycles for each count, the reset wait count, which protection setting blocks which direction, the read-versus-write hold difference, and an option write made during an access being deferred.

// File: rtl/cs_term_pkg.sv
package cs_term_pkg;
  localparam int WS_W  = 5;
  localparam int CFG_W = WS_W + 3;

  typedef struct packed {
    logic            rd_hold;
    logic            wr_only;
    logic            prot_en;
    logic [WS_W-1:0] wait_n;
  } cs_opt_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2,
    ST_VIOL = 2'd3
  } cs_state_t;
endpackage

// File: rtl/cs_rst_sync.sv
module cs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cs_opt_reg.sv
module cs_opt_reg
  import cs_term_pkg::*;
#(
  parameter int WS_RESET = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output cs_opt_t          opt_q
);
  cs_opt_t opt_d;

  always_comb begin
    opt_d = opt_q;
    if (we) opt_d = cs_opt_t'(wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q.rd_hold <= 1'b0;
      opt_q.wr_only <= 1'b0;
      opt_q.prot_en <= 1'b0;
      opt_q.wait_n  <= WS_W'(WS_RESET);
    end else begin
      opt_q <= opt_d;
    end
  end
endmodule

// File: rtl/cs_term_ctr.sv
module cs_term_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
  import cs_term_pkg::*;
#(
  parameter int TMO_CYCLES = 256,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_write,
  input  cs_opt_t          opt_q,
  input  logic             ext_ack,
  input  logic [CNT_W-1:0] cnt,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             cs_active,
  output logic             ack_out,
  output logic             addr_valid,
  output logic             prot_err,
  output logic             bus_err
);
  localparam logic [WS_W-1:0]  WS_EXT   = '1;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TMO_CYCLES - 1);

  cs_state_t       state_q, state_d;
  logic [WS_W-1:0] snap_ws_q, snap_ws_d;
  logic            snap_hold_q, snap_hold_d;
  logic            snap_wr_q, snap_wr_d;
  logic            viol;
  logic            ext_mode, done_int, done_ext, tmo_hit, term;

  // direction check against the live option value at acceptance
  always_comb begin
    viol = opt_q.prot_en && (opt_q.wr_only != req_write);
  end

  always_comb begin
    ext_mode = (snap_ws_q == WS_EXT);
    done_int = !ext_mode && (cnt == CNT_W'(snap_ws_q));
    done_ext = ext_mode && ext_ack;
    tmo_hit  = ext_mode && !ext_ack && (cnt == TMO_LAST);
    term     = done_int || done_ext || tmo_hit;
  end

  always_comb begin
    state_d     = state_q;
    snap_ws_d   = snap_ws_q;
    snap_hold_d = snap_hold_q;
    snap_wr_d   = snap_wr_q;
    cnt_clr     = 1'b0;
    cnt_en      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (viol) begin
            state_d = ST_VIOL;
          end else begin
            state_d     = ST_BUSY;
            snap_ws_d   = opt_q.wait_n;
            snap_hold_d = opt_q.rd_hold;
            snap_wr_d   = req_write;
            cnt_clr     = 1'b1;
          end
        end
      end
      ST_BUSY: begin
        cnt_en = 1'b1;
        if (term) begin
          state_d = (!snap_wr_q && snap_hold_q) ? ST_HOLD : ST_IDLE;
        end
      end
      ST_HOLD: state_d = ST_IDLE;
      ST_VIOL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      snap_ws_q   <= '0;
      snap_hold_q <= 1'b0;
      snap_wr_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      snap_ws_q   <= snap_ws_d;
      snap_hold_q <= snap_hold_d;
      snap_wr_q   <= snap_wr_d;
    end
  end

  always_comb begin
    cs_active  = (state_q == ST_BUSY);
    ack_out    = cs_active && (done_int || done_ext);
    bus_err    = cs_active && tmo_hit;
    addr_valid = cs_active || (state_q == ST_HOLD);
    prot_err   = (state_q == ST_VIOL);
  end
endmodule

// File: rtl/cs_access_term.sv
module cs_access_term
  import cs_term_pkg::*;
#(
  parameter int WS_RESET   = 30,
  parameter int TMO_CYCLES = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_hit,
  input  logic             ext_ack,
  output logic             cs_active,
  output logic             ack_out,
  output logic             addr_valid,
  output logic             prot_err,
  output logic             bus_err
);
  localparam int TMO_W = $clog2(TMO_CYCLES);
  localparam int CNT_W = (TMO_W > WS_W) ? TMO_W : WS_W;

  logic             rst_n_sync;
  cs_opt_t          opt_q;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cnt_en;
  logic             start;

  assign start = req_valid && req_hit;

  cs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  cs_opt_reg #(.WS_RESET(WS_RESET)) u_opt (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .opt_q (opt_q)
  );

  cs_term_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (cnt_clr),
    .en    (cnt_en),
    .cnt   (cnt)
  );

  cs_seq_fsm #(.TMO_CYCLES(TMO_CYCLES), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start      (start),
    .req_write  (req_write),
    .opt_q      (opt_q),
    .ext_ack    (ext_ack),
    .cnt        (cnt),
    .cnt_clr    (cnt_clr),
    .cnt_en     (cnt_en),
    .cs_active  (cs_active),
    .ack_out    (ack_out),
    .addr_valid (addr_valid),
    .prot_err   (prot_err),
    .bus_err    (bus_err)
  );
endmodule

// File: rtl/cs_access_term_chk.sv
module cs_access_term_chk #(
  parameter int TMO_CYCLES = 256
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_hit,
  input logic cs_active,
  input logic ack_out,
  input logic addr_valid,
  input logic prot_err,
  input logic bus_err
);
  localparam int RUN_W = $clog2(TMO_CYCLES) + 1;
  logic [RUN_W-1:0] cs_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cs_run <= '0;
    else if (cs_active) cs_run <= cs_run + 1'b1;
    else                cs_run <= '0;
  end

  p_cs_needs_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_active) |-> $past(req_valid && req_hit));
  p_ack_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> cs_active);
  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |=> !ack_out);
  p_cs_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |=> !cs_active);
  p_tmo_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_active |-> (cs_run < RUN_W'(TMO_CYCLES)));
  p_berr_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (cs_active && !ack_out));
  p_berr_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !cs_active);
  p_av_cover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_active |-> addr_valid);
  p_hold_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_active && addr_valid) |=> !addr_valid);
  p_prot_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> (!cs_active && !ack_out && !addr_valid));
  p_prot_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> !prot_err);
endmodule

bind cs_access_term cs_access_term_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_hit    (req_hit),
  .cs_active  (cs_active),
  .ack_out    (ack_out),
  .addr_valid (addr_valid),
  .prot_err   (prot_err),
  .bus_err    (bus_err)
);

// File: tb/test_cs_access_term.sv
module test_cs_access_term;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       req_valid, req_write, req_hit, ext_ack;
  logic       cs_active, ack_out, addr_valid, prot_err, bus_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int r_ncs, r_first_cs, r_ack_at, r_nack, r_err_at, r_prot_at, r_av_last;

  cs_access_term i_cs_access_term (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_hit(req_hit),
    .ext_ack(ext_ack), .cs_active(cs_active), .ack_out(ack_out),
    .addr_valid(addr_valid), .prot_err(prot_err), .bus_err(bus_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // issue one request, then record the output timeline, cycle 1 = first after acceptance
  task automatic run_access(input logic wr, input logic hit, input int ext_at,
                            input int cfg_at, input logic [7:0] cfg_val, input int req_at);
    r_ncs = 0; r_first_cs = 0; r_ack_at = 0; r_nack = 0;
    r_err_at = 0; r_prot_at = 0; r_av_last = 0;
    @(negedge clk);
    req_valid = 1'b1; req_hit = hit; req_write = wr;
    @(posedge clk);
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      req_valid = (k == req_at);
      req_hit   = 1'b1;
      cfg_we    = (k == cfg_at);
      cfg_wdata = cfg_val;
      ext_ack   = (k == ext_at);
      #1;
      if (cs_active) begin
        r_ncs++;
        if (r_first_cs == 0) r_first_cs = k;
      end
      if (ack_out) begin r_nack++; r_ack_at = k; end
      if (bus_err) r_err_at = k;
      if (prot_err) r_prot_at = k;
      if (addr_valid) r_av_last = k;
      if (!cs_active && !addr_valid && !prot_err) break;
    end
    req_valid = 1'b0; cfg_we = 1'b0; ext_ack = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0;
    req_valid = 0; req_write = 0; req_hit = 0; ext_ack = 0;
    repeat (3) @(negedge clk);
    check({cs_active, ack_out, addr_valid, prot_err, bus_err} == 5'b0, "R8 outputs low in reset",
          {cs_active, ack_out, addr_valid, prot_err, bus_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_access(1'b0, 1'b1, 0, 0, 8'h00, 0);
    check(r_ncs == 31, "R8 reset wait count 30", r_ncs, 31);
    check(r_ack_at == 31, "R8 ack after 30 waits", r_ack_at, 31);
    check(r_av_last == 31, "R8 read hold off after reset", r_av_last, 31);
    run_access(1'b1, 1'b1, 0, 0, 8'h00, 0);
    check(r_prot_at == 0 && r_nack == 1, "R8 protection off after reset", r_prot_at, 0);
  endtask

  task automatic t_wait(input int ws, input logic wr);
    cfg(8'(ws));
    run_access(wr, 1'b1, 0, 0, 8'h00, 0);
    check(r_first_cs == 1, "R1 cs one cycle after hit", r_first_cs, 1);
    check(r_ncs == ws + 1, "R2 cs length", r_ncs, ws + 1);
    check(r_ack_at == ws + 1, "R2 ack position", r_ack_at, ws + 1);
    check(r_nack == 1, "R3 single ack", r_nack, 1);
  endtask

  task automatic t_miss;
    cfg(8'd2);
    run_access(1'b0, 1'b0, 0, 0, 8'h00, 0);
    check(r_ncs == 0 && r_av_last == 0, "R1 no hit starts nothing", r_ncs, 0);
  endtask

  task automatic t_ext;
    cfg(8'd31);
    run_access(1'b0, 1'b1, 5, 0, 8'h00, 0);
    check(r_ncs == 5, "R4 ext ack ends cycle", r_ncs, 5);
    check(r_ack_at == 5 && r_nack == 1, "R4 ack with ext ack", r_ack_at, 5);
    check(r_err_at == 0, "R4 no bus error", r_err_at, 0);
    @(negedge clk); ext_ack = 1'b1; #1;
    check(ack_out == 1'b0 && cs_active == 1'b0, "R4 ext ack idle ignored", ack_out, 0);
    @(negedge clk); ext_ack = 1'b0;
  endtask

  task automatic t_timeout;
    cfg(8'd31);
    run_access(1'b1, 1'b1, 0, 0, 8'h00, 0);
    check(r_ncs == 256, "R5 timeout cs length", r_ncs, 256);
    check(r_err_at == 256, "R5 bus error position", r_err_at, 256);
    check(r_nack == 0, "R5 no ack on timeout", r_nack, 0);
  endtask

  task automatic t_hold;
    cfg(8'h82);
    run_access(1'b0, 1'b1, 0, 0, 8'h00, 0);
    check(r_av_last == r_ncs + 1 && r_ncs == 3, "R6 read hold extra cycle", r_av_last, 4);
    run_access(1'b1, 1'b1, 0, 0, 8'h00, 0);
    check(r_av_last == r_ncs && r_ncs == 3, "R6 write not held", r_av_last, 3);
    cfg(8'h02);
    run_access(1'b0, 1'b1, 0, 0, 8'h00, 0);
    check(r_av_last == 3, "R6 read without hold", r_av_last, 3);
  endtask

  task automatic t_prot;
    cfg(8'h21); // read-only
    run_access(1'b1, 1'b1, 0, 0, 8'h00, 0);
    check(r_prot_at == 1, "R7 write to read-only flagged", r_prot_at, 1);
    check(r_ncs == 0 && r_nack == 0 && r_av_last == 0, "R7 violation quiet", r_ncs, 0);
    run_access(1'b0, 1'b1, 0, 0, 8'h00, 0);
    check(r_prot_at == 0 && r_nack == 1 && r_ncs == 2, "R7 read to read-only ok", r_ncs, 2);
    cfg(8'h61); // write-only
    run_access(1'b0, 1'b1, 0, 0, 8'h00, 0);
    check(r_prot_at == 1 && r_ncs == 0, "R7 read to write-only flagged", r_prot_at, 1);
    run_access(1'b1, 1'b1, 0, 0, 8'h00, 0);
    check(r_prot_at == 0 && r_ncs == 2, "R7 write to write-only ok", r_ncs, 2);
  endtask

  task automatic t_busy;
    cfg(8'd20);
    run_access(1'b0, 1'b1, 0, 3, 8'd0, 4);
    check(r_ncs == 21, "R9 write during access deferred", r_ncs, 21);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(cs_active == 1'b0, "R1 request during access dropped", cs_active, 0);
    end
    run_access(1'b0, 1'b1, 0, 0, 8'h00, 0);
    check(r_ncs == 1, "R9 new value on next access", r_ncs, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wait(0, 1'b0);
    t_wait(1, 1'b1);
    t_wait(10, 1'b0);
    t_wait(30, 1'b1);
    t_miss();
    t_ext();
    t_timeout();
    t_hold();
    t_prot();
    t_busy();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule